// File: doc/BRIEF.md
# Dual-Page Video Pixel Combiner

This block sits behind the video memory fetch of a bitmap display. Once per character cell a byte pair arrives: one byte from each of two video pages, read together. The block first undoes one of four byte-storage orderings, then applies one of eight layouts. The result is a stream of 4-bit palette indices, one per dot. It emits the first dot of a pair in the cycle that loads the pair. Each later dot waits for the dot tick selected by the dot-rate field, so a pair yields 16, 8 or 4 dots at the full, half or quarter tick rate. Outside the active picture area every emitted dot is the border colour.

A mode register and a border register are written through a small write port. The palette index keeps its value between emitted dots. In every generated colour the top bit is inverted, so a raw value v becomes v XOR 8. Address generation and the palette lookup sit outside this block.

Top module: `dual_page_pixel_combiner`

## Requirements
- R1: After reset the output index is 0, the border is 0 and the mode is 0 (legacy ordering, half dot rate, attribute layout).
- R2: A write with select 0 loads the mode: bits 6:5 ordering (00 legacy, 01 direct, 10 interleaved, 11 transposed), bits 4:3 dot rate (01 full, 00 and 10 half, 11 quarter), bits 2:0 layout (000 attribute, 001 four-colour, 010 high-resolution, 011 sixteen-colour, 100 page-A only, 101 page-B only, 110 overprint, 111 triple overprint). A write with select 1 loads the border from bits 3:0.
- R3: A load emits dot 0 in its own cycle. After that, dot n is emitted on every 1st, 2nd or 4th tick for the full, half or quarter rate. The output holds its value in cycles that emit nothing.
- R4: A dot emitted while the active flag is low takes the border value.
- R5: Legacy ordering treats page B stored as bits AEFGHBCD (MSB first) as the byte ABCDEFGH, and leaves page A unchanged. Attribute layout uses page-A bit 7-n of dot n to choose the upper nibble of page B (bit 1) or the lower nibble (bit 0). The chosen nibble is XORed with 8.
- R6: Writing A7..A0 and B7..B0 for the direct bytes: interleaved storage holds A7,B7,A6,B6,...,A0,B0 across page A then page B. Transposed storage holds, for j=0..3 in turn, A(7-j),A(3-j),B(7-j),B(3-j).
- R7: The four-colour layout gives dot n the index 8 + 2*B(7-n) + A(7-n).
- R8: The high-resolution layout gives 16 dots. An even dot 2k takes A(7-k) and an odd dot 2k+1 takes B(7-k). The index is 8 plus that bit.
- R9: The sixteen-colour layout gives four dots from A[7:4], A[3:0], B[7:4] and B[3:0], each XORed with 8.
- R10: Page-A-only gives 9 when A(7-n) is set and 8 otherwise. Page-B-only gives 10 when B(7-n) is set and 8 otherwise.
- R11: Overprint gives 9 when A(7-n) is set, 10 when only B(7-n) is set, and 8 when neither is set.
- R12: Triple overprint forms c = nibble XOR 8 as in R9, then sends c 0..7 to 0, c 12..15 to 12 and c 11 to 10. The index is therefore always one of 0, 8, 9, 10 or 12.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Full-rate dot tick |
| load_i | input | 1 | Byte pair strobe, once per fetch |
| page_a_i | input | 8 | Byte from video page A |
| page_b_i | input | 8 | Byte from video page B |
| active_i | input | 1 | High inside the picture area |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | 0 = mode, 1 = border |
| wr_data_i | input | 7 | Register write data |
| pix_idx_o | output | 4 | Palette index |

## Verification
A wrong dot counter or rate divider moves a pixel to the wrong cycle. The bench catches this within one fetch, because it checks the index in every cycle after a load, including the hold cycles. A bad ordering permutation or a stale stored pair puts a wrong index on the first mismatching dot. Each ordering is driven with asymmetric byte patterns, so a single swapped bit shows up within 16 cycles. A wrong layout remap shows on the next emitted dot that uses the affected colour value.

// File: rtl/vcomb_pkg.sv
`timescale 1ns/1ps
package vcomb_pkg;

    localparam int BYTE_W  = 8;
    localparam int IDX_W   = 4;
    localparam int POS_W   = 4;
    localparam int SUB_W   = 2;
    localparam logic [IDX_W-1:0] IDX_FLIP = 4'h8;

    typedef enum logic [1:0] {
        XC_LEGACY = 2'b00,
        XC_DIRECT = 2'b01,
        XC_INTLV  = 2'b10,
        XC_TRANS  = 2'b11
    } xcode_e;

    typedef enum logic [1:0] {
        DR_HALF  = 2'b00,
        DR_FULL  = 2'b01,
        DR_HALF2 = 2'b10,
        DR_QUART = 2'b11
    } dotrate_e;

    typedef enum logic [2:0] {
        LY_ATTR   = 3'd0,
        LY_BM4    = 3'd1,
        LY_HIRES  = 3'd2,
        LY_BM16   = 3'd3,
        LY_PGA    = 3'd4,
        LY_PGB    = 3'd5,
        LY_OVER   = 3'd6,
        LY_TRIPLE = 3'd7
    } layout_e;

    typedef struct packed {
        xcode_e   xc;
        dotrate_e rate;
        layout_e  lay;
    } mode_t;

    localparam int MODE_W = $bits(mode_t);

    typedef struct packed {
        logic [BYTE_W-1:0] pa;
        logic [BYTE_W-1:0] pb;
    } pair_t;

    // Ticks per dot minus one, as a wrap mask for the sub-dot counter.
    function automatic logic [SUB_W-1:0] rate_mask(input dotrate_e r);
        case (r)
            DR_FULL:  rate_mask = 2'd0;
            DR_QUART: rate_mask = 2'd3;
            default:  rate_mask = 2'd1;
        endcase
    endfunction

    // Undo the storage ordering so that every layout sees direct-form bytes.
    function automatic pair_t to_direct(input pair_t s, input xcode_e xc);
        logic [2*BYTE_W-1:0] w;
        logic [2*BYTE_W-1:0] o;
        w = {s.pa, s.pb};
        o = w;
        case (xc)
            XC_LEGACY: begin
                o[7] = w[7]; o[6] = w[2]; o[5] = w[1]; o[4] = w[0];
                o[3] = w[6]; o[2] = w[5]; o[1] = w[4]; o[0] = w[3];
            end
            XC_INTLV: begin
                for (int k = 0; k < 8; k++) begin
                    o[15-k] = w[15-2*k];
                    o[7-k]  = w[14-2*k];
                end
            end
            XC_TRANS: begin
                for (int j = 0; j < 4; j++) begin
                    o[15-j] = w[15-4*j];
                    o[11-j] = w[14-4*j];
                    o[7-j]  = w[13-4*j];
                    o[3-j]  = w[12-4*j];
                end
            end
            default: o = w;
        endcase
        to_direct = pair_t'(o);
    endfunction

    // Palette index of dot p for a direct-form pair.
    function automatic logic [IDX_W-1:0] pick_color(input pair_t d, input layout_e ly,
                                                    input logic [POS_W-1:0] p);
        logic             a8, b8, hb;
        logic [IDX_W-1:0] nib, c;
        a8 = d.pa[~p[2:0]];
        b8 = d.pb[~p[2:0]];
        hb = p[0] ? d.pb[~p[3:1]] : d.pa[~p[3:1]];
        case (p[1:0])
            2'd0:    nib = d.pa[7:4];
            2'd1:    nib = d.pa[3:0];
            2'd2:    nib = d.pb[7:4];
            default: nib = d.pb[3:0];
        endcase
        case (ly)
            LY_ATTR:  c = (a8 ? d.pb[7:4] : d.pb[3:0]) ^ IDX_FLIP;
            LY_BM4:   c = {2'b10, b8, a8};
            LY_HIRES: c = {3'b100, hb};
            LY_BM16:  c = nib ^ IDX_FLIP;
            LY_PGA:   c = {3'b100, a8};
            LY_PGB:   c = {2'b10, b8, 1'b0};
            LY_OVER:  c = a8 ? 4'd9 : (b8 ? 4'd10 : 4'd8);
            default: begin
                c = nib ^ IDX_FLIP;
                if (!c[3])              c = 4'd0;
                else if (c[3:2] == 2'b11) c = 4'd12;
                else if (c == 4'd11)    c = 4'd10;
            end
        endcase
        pick_color = c;
    endfunction

endpackage

// File: rtl/vcomb_regs.sv
`timescale 1ns/1ps
module vcomb_regs
    import vcomb_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en_i,
    input  logic                wr_sel_i,
    input  logic [MODE_W-1:0]   wr_data_i,
    output mode_t               mode_o,
    output logic [IDX_W-1:0]    border_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_o   <= '0;
            border_o <= '0;
        end else if (wr_en_i) begin
            if (!wr_sel_i) mode_o   <= mode_t'(wr_data_i);
            else           border_o <= wr_data_i[IDX_W-1:0];
        end
    end

    p_border_write_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_sel_i) |=> $stable(mode_o));

endmodule

// File: rtl/vcomb_dotgen.sv
`timescale 1ns/1ps
module vcomb_dotgen
    import vcomb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              load_i,
    input  dotrate_e          rate_i,
    output logic              emit_o,
    output logic [POS_W-1:0]  pix_sel_o
);

    logic [SUB_W-1:0] sub_q;
    logic [POS_W-1:0] pos_q;
    logic [SUB_W-1:0] mask;

    assign mask      = rate_mask(rate_i);
    assign emit_o    = load_i | (tick_i & ((sub_q & mask) == '0));
    assign pix_sel_o = load_i ? '0 : pos_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sub_q <= '0;
            pos_q <= '0;
        end else if (load_i) begin
            sub_q <= SUB_W'(1) & mask;
            pos_q <= POS_W'(1);
        end else if (tick_i) begin
            sub_q <= (sub_q + SUB_W'(1)) & mask;
            if (emit_o) pos_q <= pos_q + POS_W'(1);
        end
    end

    p_full_rate_r3: assert property (@(posedge clk) disable iff (rst)
        (rate_i == DR_FULL && tick_i) |-> emit_o);

    p_needs_tick_r3: assert property (@(posedge clk) disable iff (rst)
        emit_o |-> (tick_i || load_i));

    p_quarter_gap_r3: assert property (@(posedge clk) disable iff (rst)
        (rate_i == DR_QUART && emit_o && !load_i) |=> !(emit_o && !load_i));

endmodule

// File: rtl/vcomb_datapath.sv
`timescale 1ns/1ps
module vcomb_datapath
    import vcomb_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load_i,
    input  logic               emit_i,
    input  logic [POS_W-1:0]   pix_sel_i,
    input  logic               active_i,
    input  logic [IDX_W-1:0]   border_i,
    input  mode_t              mode_i,
    input  logic [BYTE_W-1:0]  page_a_i,
    input  logic [BYTE_W-1:0]  page_b_i,
    output logic [IDX_W-1:0]   idx_o
);

    pair_t            word_q;
    pair_t            incoming;
    pair_t            src;
    logic [IDX_W-1:0] colour;

    assign incoming = to_direct('{pa: page_a_i, pb: page_b_i}, mode_i.xc);
    assign src      = load_i ? incoming : word_q;
    assign colour   = pick_color(src, mode_i.lay, pix_sel_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            idx_o  <= '0;
        end else begin
            if (load_i) word_q <= incoming;
            if (emit_i) idx_o  <= active_i ? colour : border_i;
        end
    end

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !emit_i |=> $stable(idx_o));

    p_border_r4: assert property (@(posedge clk) disable iff (rst)
        (emit_i && !active_i) |=> (idx_o == $past(border_i)));

    p_pga_pair_r10: assert property (@(posedge clk) disable iff (rst)
        (emit_i && active_i && mode_i.lay == LY_PGA) |=> (idx_o[3:1] == 3'b100));

    p_triple_set_r12: assert property (@(posedge clk) disable iff (rst)
        (emit_i && active_i && mode_i.lay == LY_TRIPLE) |=>
        (idx_o == 4'd0 || idx_o == 4'd8 || idx_o == 4'd9 ||
         idx_o == 4'd10 || idx_o == 4'd12));

endmodule

// File: rtl/dual_page_pixel_combiner.sv
`timescale 1ns/1ps
module dual_page_pixel_combiner
    import vcomb_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                tick_i,
    input  logic                load_i,
    input  logic [BYTE_W-1:0]   page_a_i,
    input  logic [BYTE_W-1:0]   page_b_i,
    input  logic                active_i,
    input  logic                wr_en_i,
    input  logic                wr_sel_i,
    input  logic [MODE_W-1:0]   wr_data_i,
    output logic [IDX_W-1:0]    pix_idx_o
);

    mode_t            mode;
    logic [IDX_W-1:0] border;
    logic             emit;
    logic [POS_W-1:0] pix_sel;

    vcomb_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (wr_en_i),
        .wr_sel_i  (wr_sel_i),
        .wr_data_i (wr_data_i),
        .mode_o    (mode),
        .border_o  (border)
    );

    vcomb_dotgen u_dotgen (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (tick_i),
        .load_i    (load_i),
        .rate_i    (mode.rate),
        .emit_o    (emit),
        .pix_sel_o (pix_sel)
    );

    vcomb_datapath u_dp (
        .clk       (clk),
        .rst       (rst),
        .load_i    (load_i),
        .emit_i    (emit),
        .pix_sel_i (pix_sel),
        .active_i  (active_i),
        .border_i  (border),
        .mode_i    (mode),
        .page_a_i  (page_a_i),
        .page_b_i  (page_b_i),
        .idx_o     (pix_idx_o)
    );

    p_reset_idle_r1: assert property (@(posedge clk)
        $past(rst) |-> (pix_idx_o == '0));

endmodule

// File: tb/tb_dual_page_pixel_combiner.sv
`timescale 1ns/1ps
module tb_dual_page_pixel_combiner;

    logic       clk = 0;
    logic       rst = 1;
    logic       tick_i = 0;
    logic       load_i = 0;
    logic [7:0] page_a_i = 0;
    logic [7:0] page_b_i = 0;
    logic       active_i = 0;
    logic       wr_en_i = 0;
    logic       wr_sel_i = 0;
    logic [6:0] wr_data_i = 0;
    logic [3:0] pix_idx_o;

    int checks = 0;
    int bad = 0;

    always #10 clk = ~clk;

    dual_page_pixel_combiner dut (
        .clk(clk), .rst(rst), .tick_i(tick_i), .load_i(load_i),
        .page_a_i(page_a_i), .page_b_i(page_b_i), .active_i(active_i),
        .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
        .pix_idx_o(pix_idx_o)
    );

    task automatic check(input logic [3:0] act, input logic [3:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Storage form of a direct-form pair under each ordering (R5, R6).
    function automatic logic [15:0] encode(input int xc, input logic [7:0] da, input logic [7:0] db);
        logic [15:0] s;
        s = {da, db};
        if (xc == 0) begin
            s[7] = db[7]; s[2] = db[6]; s[1] = db[5]; s[0] = db[4];
            s[6] = db[3]; s[5] = db[2]; s[4] = db[1]; s[3] = db[0];
        end else if (xc == 2) begin
            for (int k = 0; k < 8; k++) begin
                s[15-2*k] = da[7-k];
                s[14-2*k] = db[7-k];
            end
        end else if (xc == 3) begin
            for (int j = 0; j < 4; j++) begin
                s[15-4*j] = da[7-j];
                s[14-4*j] = da[3-j];
                s[13-4*j] = db[7-j];
                s[12-4*j] = db[3-j];
            end
        end
        return s;
    endfunction

    function automatic logic [3:0] nib_of(input logic [7:0] da, input logic [7:0] db, input int p);
        case (p)
            0: return da[7:4];
            1: return da[3:0];
            2: return db[7:4];
            default: return db[3:0];
        endcase
    endfunction

    function automatic logic [3:0] expect_px(input int ly, input logic [7:0] da,
                                             input logic [7:0] db, input int p);
        logic [3:0] c;
        case (ly)
            0: return (da[7-p] ? db[7:4] : db[3:0]) ^ 4'h8;          // R5
            1: return 4'(8 + 2*db[7-p] + da[7-p]);                   // R7
            2: return (p % 2 == 0) ? 4'(8 + da[7-p/2]) : 4'(8 + db[7-p/2]); // R8
            3: return nib_of(da, db, p) ^ 4'h8;                      // R9
            4: return da[7-p] ? 4'd9 : 4'd8;                         // R10
            5: return db[7-p] ? 4'd10 : 4'd8;                        // R10
            6: return da[7-p] ? 4'd9 : (db[7-p] ? 4'd10 : 4'd8);     // R11
            default: begin                                           // R12
                c = nib_of(da, db, p) ^ 4'h8;
                if (c < 8) return 4'd0;
                if (c >= 12) return 4'd12;
                if (c == 11) return 4'd10;
                return c;
            end
        endcase
    endfunction

    task automatic write_reg(input logic sel, input logic [6:0] data);
        @(negedge clk);
        wr_en_i = 1; wr_sel_i = sel; wr_data_i = data;
        @(negedge clk);
        wr_en_i = 0;
    endtask

    // One fetch of 16 ticks; every cycle is checked, emitted or held.
    task automatic run_fetch(input int xc, input int rate, input int ly,
                             input logic [7:0] da, input logic [7:0] db,
                             input logic act, input logic [3:0] border_exp,
                             input string req);
        logic [15:0] s;
        logic [3:0]  prev;
        int          div;
        s   = encode(xc, da, db);
        div = (rate == 1) ? 1 : ((rate == 3) ? 4 : 2);
        prev = pix_idx_o;
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            load_i   = (k == 0);
            page_a_i = (k == 0) ? s[15:8] : 8'hxx;
            page_b_i = (k == 0) ? s[7:0]  : 8'hxx;
            active_i = act;
            tick_i   = 1;
            @(posedge clk);
            #2;
            if (k % div == 0)
                check(pix_idx_o, act ? expect_px(ly, da, db, k / div) : border_exp, req);
            else
                check(pix_idx_o, prev, {req, " hold R3"});
            prev = pix_idx_o;
        end
        @(negedge clk);
        load_i = 0;
        page_a_i = 0;
        page_b_i = 0;
    endtask

    task automatic run_mode(input int xc, input int rate, input int ly,
                            input logic [7:0] da, input logic [7:0] db, input string req);
        write_reg(1'b0, 7'((xc << 5) | (rate << 3) | ly));
        run_fetch(xc, rate, ly, da, db, 1'b1, 4'd0, req);
    endtask

    task automatic t_reset;
        check(pix_idx_o, 4'd0, "R1 reset index");
        run_fetch(0, 0, 0, 8'b0010_1001, 8'h3C, 1'b1, 4'd0, "R1 default mode");
    endtask

    task automatic t_attribute;
        run_mode(0, 0, 0, 8'b1100_1010, 8'h5E, "R5 legacy attribute");
        run_mode(1, 2, 0, 8'b0010_1001, 8'hA3, "R6 direct attribute rate10 R3");
        run_mode(2, 0, 0, 8'b0110_0101, 8'h71, "R6 interleaved attribute");
        run_mode(3, 0, 0, 8'b1001_0110, 8'hC4, "R6 transposed attribute");
    endtask

    task automatic t_bitmaps;
        run_mode(1, 0, 1, 8'b1100_1010, 8'b1010_0110, "R7 four-colour direct");
        run_mode(2, 0, 1, 8'b0111_0001, 8'b1101_1000, "R7 four-colour interleaved R6");
        run_mode(1, 1, 2, 8'b1011_0010, 8'b0110_1101, "R8 high-res direct");
        run_mode(3, 1, 2, 8'b1000_1110, 8'b0101_0011, "R8 high-res transposed R6");
        run_mode(1, 3, 3, 8'h4F, 8'hB2, "R9 sixteen-colour direct");
        run_mode(2, 3, 3, 8'h1E, 8'hC7, "R9 sixteen-colour interleaved R6");
    endtask

    task automatic t_pages;
        run_mode(1, 0, 4, 8'b1011_0100, 8'hFF, "R10 page A only");
        run_mode(1, 0, 5, 8'h00, 8'b0110_1011, "R10 page B only");
        run_mode(1, 0, 6, 8'b1100_1000, 8'b1010_1100, "R11 overprint");
    endtask

    task automatic t_triple;
        run_mode(1, 3, 7, 8'h3B, 8'h4C, "R12 triple remap");
        run_mode(1, 3, 7, 8'h01, 8'hE5, "R12 triple kept");
    endtask

    task automatic t_border;
        write_reg(1'b1, 7'h05);
        write_reg(1'b0, 7'((1 << 5) | (0 << 3) | 1));
        run_fetch(1, 0, 1, 8'hA5, 8'h3C, 1'b0, 4'd5, "R4 border outside active R2");
        write_reg(1'b1, 7'h0C);
        run_fetch(1, 0, 1, 8'h5A, 8'hC3, 1'b0, 4'd12, "R4 border rewritten R2");
    endtask

    initial begin
        #(20 * 200000);
        bad++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        t_reset();
        t_attribute();
        t_bitmaps();
        t_pages();
        t_triple();
        t_border();
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule